// File: doc/BRIEF.md
# MII Nibble Datapath with Internal Loopback

This block joins a MAC that works in bytes to an external PHY that uses the 4-bit Media Independent Interface. On the transmit side it takes bytes through a valid/ready handshake and sends each one as two nibbles on `mii_txd` with `mii_tx_en` high. On the receive side it collects nibbles framed by `mii_rx_dv` into bytes, marks bytes that arrived with a receive error, and flags a frame that ended on an odd nibble. The PHY supplies both clocks, 25 MHz at 100 Mbit/s or 2.5 MHz at 10 Mbit/s. The transmit and receive halves have separate clocks and separate synchronous active-low resets. They share no state, so either clock may run at its own rate, slow down or stop without disturbing the other half.

An internal loopback input sends the registered transmit nibble stream straight into a second byte assembler that runs on the transmit clock. While it is high, the receive byte outputs come from that assembler and so are timed by `tx_clk`. The PHY receive pins are ignored in that mode. The transmit error marker is not carried round the loop. The collision and carrier-sense inputs pass through a synchronizer into the transmit clock domain and appear on the status outputs.

Top module: `mii_nibble_path`

## Requirements
- R1: After reset, `mii_tx_en`, `mii_tx_er` and `mii_txd` are 0 and `tx_ready` is 1. `rx_byte_valid` and `rx_odd_nibble` are 0.
- R2: A byte accepted at a `tx_clk` edge drives bits [3:0] onto `mii_txd` in the following cycle and bits [7:4] in the cycle after that, with `mii_tx_en` high in both cycles.
- R3: `tx_ready` is low while the low nibble is on the wire and high while the high nibble is on the wire. A byte offered in that second cycle is accepted, so back-to-back bytes keep `mii_tx_en` high with no gap.
- R4: When no byte is pending after the high nibble, `mii_tx_en` drops to 0 and `mii_txd` reads 0.
- R5: `mii_tx_er` equals the `tx_err` value that came with the byte, for both of its nibbles.
- R6: On the receive side, the first nibble with `mii_rx_dv` high forms bits [3:0] and the second forms bits [7:4]. `rx_byte_valid` is high for exactly the one `rx_clk` cycle that follows the edge that sampled the second nibble.
- R7: `rx_byte_err` is 1 with a completed byte when `mii_rx_er` was high on either of its two nibbles, and 0 otherwise.
- R8: When `mii_rx_dv` falls after an odd number of nibbles, the leftover nibble produces no byte and `rx_odd_nibble` pulses for one cycle. A frame with an even number of nibbles does not raise the flag.
- R9: With `loopback` high, an accepted transmit byte appears on `rx_byte`, and `rx_byte_valid` is high in the cycle after the third `tx_clk` edge, counting the accepting edge. Activity on `mii_rx_dv` and `mii_rxd` does not produce a byte in that mode.
- R10: With `loopback` high, `rx_byte_err` is 0 on looped bytes even when `tx_err` was 1.
- R11: `col_status` and `crs_status` follow `mii_col` and `mii_crs` after SYNC_STAGES `tx_clk` edges (2 by default).
- R12: With `tx_clk` stopped, the receive path still assembles bytes correctly and the transmit outputs keep their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock from the PHY |
| tx_rst_n | input | 1 | Synchronous active-low reset, transmit domain |
| tx_byte | input | 8 | Byte offered by the MAC |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_err | input | 1 | Mark this byte with a transmit error |
| tx_ready | output | 1 | Byte taken at the edge when high with `tx_valid` |
| loopback | input | 1 | Route the transmit nibble stream into the receive path |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| mii_tx_en | output | 1 | Transmit enable to the PHY |
| mii_tx_er | output | 1 | Transmit error to the PHY |
| rx_clk | input | 1 | Receive clock from the PHY |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| mii_rxd | input | 4 | Receive nibble from the PHY |
| mii_rx_dv | input | 1 | Receive data valid from the PHY |
| mii_rx_er | input | 1 | Receive error from the PHY |
| rx_byte | output | 8 | Assembled byte |
| rx_byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_byte_err | output | 1 | Error seen on the byte, valid with the strobe |
| rx_odd_nibble | output | 1 | One-cycle flag: frame ended on an odd nibble |
| mii_col | input | 1 | Collision from the PHY |
| mii_crs | input | 1 | Carrier sense from the PHY |
| col_status | output | 1 | `mii_col` synchronized to `tx_clk` |
| crs_status | output | 1 | `mii_crs` synchronized to `tx_clk` |

## Verification
In the same `tx_clk` cycle, the serializer drives the high nibble of one byte and takes the next byte from the handshake. The bench provokes this by holding `tx_valid` high across a three-byte burst, changing `tx_byte` only while `tx_ready` is low. At every falling edge it checks that `mii_tx_en` never drops, that the nibbles come out low half first, and that `tx_ready` alternates. On the receive side, the strobe for one byte falls in the same cycle that the first nibble of the next byte is captured. Checks at each falling edge of `rx_clk` confirm that the strobe lasts exactly one cycle and that the byte value and error marker are correct.

// File: rtl/mii_nib_pkg.sv
// Shared constants and types for the MII nibble datapath.
// Assumes the nibble width is half of a byte; everything derives from it.
package mii_nib_pkg;
    localparam int MII_NIB_W  = 4;
    localparam int MII_BYTE_W = 2 * MII_NIB_W;

    // Which half of the byte the serializer sends on its next cycle.
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } tx_phase_e;
endpackage

// File: rtl/mii_tx_serializer.sv
// Byte-to-nibble transmit serializer.
// Takes one byte per handshake and sends its low nibble, then its high nibble,
// with the enable high in both cycles. It will not take a byte while the low
// nibble is being sent. Runs entirely in the PHY transmit clock domain.
// Assumes in_byte and in_err stay stable while in_valid waits for in_ready.
module mii_tx_serializer
    import mii_nib_pkg::*;
#(
    parameter int NIB_W = MII_NIB_W,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_err,
    output logic              in_ready,
    output logic [NIB_W-1:0]  out_nib,
    output logic              out_en,
    output logic              out_er
);

    tx_phase_e        phase;
    logic [NIB_W-1:0] hi_q;
    logic             err_q;
    logic             take;

    // Ready only when the next cycle would otherwise send a low nibble or be idle.
    assign in_ready = (phase == PH_LO);
    assign take     = in_valid && in_ready;

    // Nibble sequencer: low half on acceptance, high half on the cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LO;
            hi_q    <= '0;
            err_q   <= 1'b0;
            out_nib <= '0;
            out_en  <= 1'b0;
            out_er  <= 1'b0;
        end else if (take) begin
            out_nib <= in_byte[NIB_W-1:0];
            hi_q    <= in_byte[BYTE_W-1:NIB_W];
            out_en  <= 1'b1;
            out_er  <= in_err;
            err_q   <= in_err;
            phase   <= PH_HI;
        end else if (phase == PH_HI) begin
            out_nib <= hi_q;
            out_en  <= 1'b1;
            out_er  <= err_q;
            phase   <= PH_LO;
        end else begin
            out_nib <= '0;
            out_en  <= 1'b0;
            out_er  <= 1'b0;
        end
    end

    AST_LO_NIBBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_en && out_nib == $past(in_byte[NIB_W-1:0]))); // R2
    AST_HI_NIBBLE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 (out_en && out_nib == $past(in_byte[BYTE_W-1:NIB_W], 2))); // R2
    AST_READY_LOW_MID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R3
    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (!out_en && out_nib == '0)); // R4
    AST_ER_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_er == $past(in_err))); // R5

endmodule

// File: rtl/mii_rx_assembler.sv
// Nibble-to-byte receive assembler.
// While nib_dv is high, nibbles pair up as low half then high half. A completed
// byte gives a one-cycle byte_vld strobe, with byte_err set if either half had
// nib_er high. When nib_dv falls on an unpaired nibble, that nibble is dropped
// and odd_flag pulses for one cycle. Assumes a single clock for all inputs.
module mii_rx_assembler
    import mii_nib_pkg::*;
#(
    parameter int NIB_W = MII_NIB_W,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_dv,
    input  logic [NIB_W-1:0]  nib_d,
    input  logic              nib_er,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_vld,
    output logic              byte_err,
    output logic              odd_flag
);

    logic             have_lo;
    logic [NIB_W-1:0] lo_q;
    logic             er_q;

    // Pair nibbles into bytes and detect a frame that ends on half a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_lo  <= 1'b0;
            lo_q     <= '0;
            er_q     <= 1'b0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
            byte_err <= 1'b0;
            odd_flag <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            odd_flag <= 1'b0;
            if (nib_dv) begin
                if (!have_lo) begin
                    lo_q    <= nib_d;
                    er_q    <= nib_er;
                    have_lo <= 1'b1;
                end else begin
                    byte_q   <= {nib_d, lo_q};
                    byte_err <= er_q | nib_er;
                    byte_vld <= 1'b1;
                    have_lo  <= 1'b0;
                end
            end else begin
                odd_flag <= have_lo;
                have_lo  <= 1'b0;
            end
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R6
    AST_STROBE_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(nib_dv)); // R6
    AST_HIGH_HALF_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (byte_q[BYTE_W-1:NIB_W] == $past(nib_d))); // R6
    AST_ODD_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && odd_flag)); // R8
    AST_ODD_ON_DV_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        odd_flag |-> ($past(!nib_dv) && !$past(byte_vld))); // R8

endmodule

// File: rtl/mii_status_sync.sv
// Multi-stage synchronizer for slow status levels.
// Each bit passes through STAGES flops in the destination clock domain. Assumes
// the inputs are levels that stay put for several destination cycles.
module mii_status_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2,
    localparam int LAST  = STAGES - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First stage samples the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= async_in;
            end
        end else begin : g_tail
            // Later stages settle the value further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[LAST];

endmodule

// File: rtl/mii_nibble_path.sv
// MII nibble datapath between a byte-wide MAC and an external PHY.
// The transmit serializer runs on tx_clk. Two receive assemblers exist: one on
// rx_clk, fed by the PHY pins, and one on tx_clk, fed by the registered transmit
// nibbles for internal loopback. The loopback input picks which assembler drives
// the rx_* outputs, so in loopback those outputs are timed by tx_clk. The
// transmit error marker is never fed into the loop. Collision and carrier sense
// are synchronized into tx_clk. Assumes loopback changes only while both paths
// are idle.
module mii_nibble_path
    import mii_nib_pkg::*;
#(
    parameter int NIB_W       = MII_NIB_W,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = 2 * NIB_W
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    input  logic              tx_err,
    output logic              tx_ready,
    input  logic              loopback,
    output logic [NIB_W-1:0]  mii_txd,
    output logic              mii_tx_en,
    output logic              mii_tx_er,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic [NIB_W-1:0]  mii_rxd,
    input  logic              mii_rx_dv,
    input  logic              mii_rx_er,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_byte_valid,
    output logic              rx_byte_err,
    output logic              rx_odd_nibble,
    input  logic              mii_col,
    input  logic              mii_crs,
    output logic              col_status,
    output logic              crs_status
);

    localparam int N_PATH    = 2;
    localparam int PATH_PHY  = 0;
    localparam int PATH_LOOP = 1;
    localparam int N_STATUS  = 2;

    logic [NIB_W-1:0]    tx_nib;
    logic                tx_en_q;
    logic                tx_er_q;
    logic [N_STATUS-1:0] status_q;

    logic                asm_clk   [N_PATH];
    logic                asm_rst_n [N_PATH];
    logic                asm_dv    [N_PATH];
    logic [NIB_W-1:0]    asm_d     [N_PATH];
    logic                asm_er    [N_PATH];
    logic [BYTE_W-1:0]   asm_byte  [N_PATH];
    logic                asm_vld   [N_PATH];
    logic                asm_err   [N_PATH];
    logic                asm_odd   [N_PATH];

    mii_tx_serializer #(.NIB_W(NIB_W)) u_tx (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .in_byte  (tx_byte),
        .in_valid (tx_valid),
        .in_err   (tx_err),
        .in_ready (tx_ready),
        .out_nib  (tx_nib),
        .out_en   (tx_en_q),
        .out_er   (tx_er_q)
    );

    assign mii_txd   = tx_nib;
    assign mii_tx_en = tx_en_q;
    assign mii_tx_er = tx_er_q;

    for (genvar g = 0; g < N_PATH; g++) begin : g_rx_path
        if (g == PATH_PHY) begin : g_src_phy
            // PHY-fed receive path in its own clock domain.
            assign asm_clk[g]   = rx_clk;
            assign asm_rst_n[g] = rx_rst_n;
            assign asm_dv[g]    = mii_rx_dv;
            assign asm_d[g]     = mii_rxd;
            assign asm_er[g]    = mii_rx_er;
        end else begin : g_src_loop
            // Loopback path: transmit stream looped back, error marker left out.
            assign asm_clk[g]   = tx_clk;
            assign asm_rst_n[g] = tx_rst_n;
            assign asm_dv[g]    = tx_en_q;
            assign asm_d[g]     = tx_nib;
            assign asm_er[g]    = 1'b0;
        end

        mii_rx_assembler #(.NIB_W(NIB_W)) u_asm (
            .clk      (asm_clk[g]),
            .rst_n    (asm_rst_n[g]),
            .nib_dv   (asm_dv[g]),
            .nib_d    (asm_d[g]),
            .nib_er   (asm_er[g]),
            .byte_q   (asm_byte[g]),
            .byte_vld (asm_vld[g]),
            .byte_err (asm_err[g]),
            .odd_flag (asm_odd[g])
        );
    end

    // Select which assembler owns the receive byte outputs.
    always_comb begin
        if (loopback) begin
            rx_byte       = asm_byte[PATH_LOOP];
            rx_byte_valid = asm_vld[PATH_LOOP];
            rx_byte_err   = asm_err[PATH_LOOP];
            rx_odd_nibble = asm_odd[PATH_LOOP];
        end else begin
            rx_byte       = asm_byte[PATH_PHY];
            rx_byte_valid = asm_vld[PATH_PHY];
            rx_byte_err   = asm_err[PATH_PHY];
            rx_odd_nibble = asm_odd[PATH_PHY];
        end
    end

    mii_status_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_STATUS)) u_status (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .async_in ({mii_col, mii_crs}),
        .sync_out (status_q)
    );

    assign col_status = status_q[1];
    assign crs_status = status_q[0];

    AST_LOOP_ERR_LOW: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (loopback && rx_byte_valid) |-> !rx_byte_err); // R10
    AST_LOOP_STROBE_NEEDS_TX: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (loopback && rx_byte_valid) |-> $past(mii_tx_en)); // R9

endmodule

// File: tb/mii_nibble_path_bench.sv
module mii_nibble_path_bench;
    logic       tx_clk = 1'b0;
    logic       rx_clk = 1'b0;
    logic       tx_run = 1'b1;
    logic       tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_valid = 1'b0, tx_err = 1'b0, tx_ready;
    logic       loopback = 1'b0;
    logic [3:0] mii_txd;
    logic       mii_tx_en, mii_tx_er;
    logic [3:0] mii_rxd = '0;
    logic       mii_rx_dv = 1'b0, mii_rx_er = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_byte_valid, rx_byte_err, rx_odd_nibble;
    logic       mii_col = 1'b0, mii_crs = 1'b0;
    logic       col_status, crs_status;

    int n_chk = 0;
    int n_err = 0;

    always #4 if (tx_run) tx_clk = ~tx_clk;
    always #6 rx_clk = ~rx_clk;

    mii_nibble_path u_mii_nibble_path (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_err(tx_err), .tx_ready(tx_ready), .loopback(loopback), .mii_txd(mii_txd),
        .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
        .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .rx_byte(rx_byte),
        .rx_byte_valid(rx_byte_valid), .rx_byte_err(rx_byte_err), .rx_odd_nibble(rx_odd_nibble),
        .mii_col(mii_col), .mii_crs(mii_crs), .col_status(col_status), .crs_status(crs_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: idle values right after reset.
    task automatic t_reset;
        @(negedge tx_clk);
        check(mii_tx_en == 1'b0, "R1 tx_en", mii_tx_en, 0);
        check(mii_tx_er == 1'b0, "R1 tx_er", mii_tx_er, 0);
        check(mii_txd == 4'h0, "R1 txd", mii_txd, 0);
        check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        @(negedge rx_clk);
        check(rx_byte_valid == 1'b0, "R1 rx valid", rx_byte_valid, 0);
        check(rx_odd_nibble == 1'b0, "R1 odd", rx_odd_nibble, 0);
    endtask

    // R2 R4 R5: one byte, low nibble then high nibble, then idle.
    task automatic t_tx_single(input logic [7:0] b, input logic e);
        @(negedge tx_clk);
        tx_byte = b; tx_err = e; tx_valid = 1'b1;
        @(negedge tx_clk);
        check(mii_tx_en && mii_txd == b[3:0], "R2 low nibble", mii_txd, b[3:0]);
        check(mii_tx_er == e, "R5 er low half", mii_tx_er, e);
        check(tx_ready == 1'b0, "R3 ready low", tx_ready, 0);
        tx_valid = 1'b0;
        @(negedge tx_clk);
        check(mii_tx_en && mii_txd == b[7:4], "R2 high nibble", mii_txd, b[7:4]);
        check(mii_tx_er == e, "R5 er high half", mii_tx_er, e);
        @(negedge tx_clk);
        check(!mii_tx_en && mii_txd == 4'h0, "R4 idle", {mii_tx_en, mii_txd}, 0);
        check(mii_tx_er == 1'b0, "R4 er idle", mii_tx_er, 0);
        tx_err = 1'b0;
    endtask

    // R3: back-to-back burst, next byte taken during the high nibble.
    task automatic t_tx_burst;
        logic [7:0] bs [3];
        bs[0] = 8'h1E; bs[1] = 8'hB7; bs[2] = 8'h60;
        @(negedge tx_clk);
        tx_byte = bs[0]; tx_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge tx_clk);
            check(mii_tx_en && mii_txd == bs[i][3:0], "R3 burst low", mii_txd, bs[i][3:0]);
            check(tx_ready == 1'b0, "R3 ready low", tx_ready, 0);
            if (i < 2) tx_byte = bs[i+1];
            else       tx_valid = 1'b0;
            @(negedge tx_clk);
            check(mii_tx_en && mii_txd == bs[i][7:4], "R3 burst high", mii_txd, bs[i][7:4]);
            check(tx_ready == 1'b1, "R3 ready high", tx_ready, 1);
        end
        @(negedge tx_clk);
        check(mii_tx_en == 1'b0, "R4 after burst", mii_tx_en, 0);
    endtask

    // R6 R7: one byte over the PHY receive pins; call at a falling rx edge.
    task automatic rx_xfer(input logic [7:0] b, input logic el, input logic eh);
        mii_rx_dv = 1'b1; mii_rxd = b[3:0]; mii_rx_er = el;
        @(negedge rx_clk);
        check(rx_byte_valid == 1'b0, "R6 no strobe on low half", rx_byte_valid, 0);
        mii_rxd = b[7:4]; mii_rx_er = eh;
        @(negedge rx_clk);
        check(rx_byte_valid == 1'b1, "R6 strobe", rx_byte_valid, 1);
        check(rx_byte == b, "R6 byte value", rx_byte, b);
        check(rx_byte_err == (el | eh), "R7 error marker", rx_byte_err, el | eh);
    endtask

    // R6 R7 R8: even-length frame, no odd flag.
    task automatic t_rx_even;
        @(negedge rx_clk);
        rx_xfer(8'hA5, 1'b0, 1'b0);
        rx_xfer(8'h3C, 1'b0, 1'b1);
        rx_xfer(8'h7E, 1'b1, 1'b0);
        mii_rx_dv = 1'b0; mii_rx_er = 1'b0; mii_rxd = 4'h0;
        @(negedge rx_clk);
        check(rx_byte_valid == 1'b0, "R6 strobe ends", rx_byte_valid, 0);
        check(rx_odd_nibble == 1'b0, "R8 no flag even", rx_odd_nibble, 0);
        @(negedge rx_clk);
        check(rx_odd_nibble == 1'b0, "R8 no flag even later", rx_odd_nibble, 0);
    endtask

    // R8: trailing odd nibble dropped and flagged.
    task automatic t_rx_odd;
        @(negedge rx_clk);
        rx_xfer(8'h96, 1'b0, 1'b0);
        mii_rxd = 4'hD;
        @(negedge rx_clk);
        check(rx_byte_valid == 1'b0, "R8 no byte from half", rx_byte_valid, 0);
        mii_rx_dv = 1'b0; mii_rxd = 4'h0;
        @(negedge rx_clk);
        check(rx_odd_nibble == 1'b1, "R8 odd flag", rx_odd_nibble, 1);
        check(rx_byte_valid == 1'b0, "R8 no byte at end", rx_byte_valid, 0);
        @(negedge rx_clk);
        check(rx_odd_nibble == 1'b0, "R8 flag one cycle", rx_odd_nibble, 0);
    endtask

    // R9 R10 R5: looped byte, PHY pins busy with junk.
    task automatic t_loop_byte(input logic [7:0] b, input logic e);
        @(negedge tx_clk);
        tx_byte = b; tx_err = e; tx_valid = 1'b1;
        @(negedge tx_clk);
        tx_valid = 1'b0;
        check(rx_byte_valid == 1'b0, "R9 no early strobe", rx_byte_valid, 0);
        check(mii_tx_er == e, "R5 er in loopback", mii_tx_er, e);
        @(negedge tx_clk);
        check(rx_byte_valid == 1'b0, "R9 no early strobe 2", rx_byte_valid, 0);
        @(negedge tx_clk);
        check(rx_byte_valid == 1'b1, "R9 looped strobe", rx_byte_valid, 1);
        check(rx_byte == b, "R9 looped byte", rx_byte, b);
        check(rx_byte_err == 1'b0, "R10 no looped error", rx_byte_err, 0);
        @(negedge tx_clk);
        check(rx_byte_valid == 1'b0, "R9 PHY pins ignored", rx_byte_valid, 0);
        tx_err = 1'b0;
    endtask

    task automatic t_loopback;
        @(negedge tx_clk);
        loopback = 1'b1;
        mii_rx_dv = 1'b1; mii_rxd = 4'hF; mii_rx_er = 1'b1;
        t_loop_byte(8'hC3, 1'b1);
        t_loop_byte(8'h5A, 1'b0);
        @(negedge tx_clk);
        mii_rx_dv = 1'b0; mii_rxd = 4'h0; mii_rx_er = 1'b0;
        repeat (3) @(negedge rx_clk);
        @(negedge tx_clk);
        loopback = 1'b0;
        repeat (2) @(negedge rx_clk);
    endtask

    // R11: status levels after the synchronizer delay.
    task automatic t_status;
        @(negedge tx_clk);
        mii_col = 1'b1; mii_crs = 1'b1;
        @(negedge tx_clk);
        check(col_status == 1'b0, "R11 col not yet", col_status, 0);
        @(negedge tx_clk);
        check(col_status == 1'b1, "R11 col set", col_status, 1);
        check(crs_status == 1'b1, "R11 crs set", crs_status, 1);
        mii_col = 1'b0;
        @(negedge tx_clk);
        check(col_status == 1'b1, "R11 col held", col_status, 1);
        @(negedge tx_clk);
        check(col_status == 1'b0, "R11 col clear", col_status, 0);
        check(crs_status == 1'b1, "R11 crs held", crs_status, 1);
        mii_crs = 1'b0;
    endtask

    // R12: receive works with tx_clk stopped.
    task automatic t_tx_stopped;
        @(negedge tx_clk);
        tx_run = 1'b0;
        @(negedge rx_clk);
        rx_xfer(8'h42, 1'b0, 1'b0);
        rx_xfer(8'hE9, 1'b0, 1'b0);
        mii_rx_dv = 1'b0;
        @(negedge rx_clk);
        check(mii_tx_en == 1'b0 && tx_ready == 1'b1, "R12 tx idle while stopped",
              {mii_tx_en, tx_ready}, 1);
        tx_run = 1'b1;
        @(negedge tx_clk);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge rx_clk);
        @(negedge tx_clk); tx_rst_n = 1'b1;
        @(negedge rx_clk); rx_rst_n = 1'b1;
        t_reset();
        t_tx_single(8'h9C, 1'b0);
        t_tx_single(8'h27, 1'b1);
        t_tx_burst();
        t_rx_even();
        t_rx_odd();
        t_loopback();
        t_status();
        t_tx_stopped();
        t_rx_even();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule